// File: doc/BRIEF.md
# Momentary Change Detect Register Bank

This block watches a set of single-bit element inputs, for example relay contacts or status points, and lets a host read two bits for any one element: its present level and a momentary flag. The momentary flag reports that the element changed level more than once since the host last read that element. A single change is not enough to raise it. Reading the pair clears the flag, so each read reports only the activity since the previous read of the same element.

Each element input first passes through a two-flop synchronizer. A small saturating counter per element then counts the edges of the synchronized level. The host presents a request with an element index. One clock later the block returns the level and the flag together, with a valid strobe, and the counter of that element restarts. A separate real-time output exposes the synchronized level of every element at all times.

Top module: `mcd_bank`

## Requirements
- R1: `rd_valid` is high in the cycle after a cycle in which `rd_req` was high, and low in every other cycle.
- R2: `rd_state` returns the synchronized level of element `rd_idx` as it stood in the request cycle. `rt_state[i]` equals `elem_in[i]` delayed by two clocks, and a read's `rd_state` equals the `rt_state` bit of that element.
- R3: An element that made exactly one transition since its last read returns `rd_moment` = 0.
- R4: An element that made two or more transitions since its last read returns `rd_moment` = 1.
- R5: A read clears the element's transition count. A following read of the same element, with no transition in between, returns `rd_moment` = 0.
- R6: An edge of the synchronized level that falls in the same cycle as a read of that element is not seen by that read. It counts as the first transition of the next interval.
- R7: The count saturates. Any number of transitions of two or more reports `rd_moment` = 1, and a single read still clears it fully.
- R8: A read clears only the counter of the element it addresses. The other elements keep their counts.
- R9: After reset `rd_valid` is 0 and every counter is 0. Input levels present while reset is applied do not register as transitions, and the `rd_state` values follow the inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| elem_in | input | N_ELEM | Element levels, asynchronous to clk |
| rd_req | input | 1 | Host read request for one element pair |
| rd_idx | input | IDX_W | Element index of the request |
| rd_valid | output | 1 | Read response strobe, one clock after the request |
| rd_state | output | 1 | Present-state bit of the addressed element |
| rd_moment | output | 1 | Momentary bit: more than one transition since the last read |
| rt_state | output | N_ELEM | Real-time synchronized level of every element |

## Verification
The assertions check on every cycle that the response strobe follows a request by one clock, that the real-time view tracks the inputs with a two-clock delay, that the returned level equals that view at the request, and that two back-to-back reads of one element never raise the flag on the second. The bench scenarios cover the counting itself: one transition against two or more, saturation after many transitions, clearing on read, the edge that coincides with a read and is carried into the next interval, independence between elements, and the absence of false transitions from input levels held during reset.

// File: rtl/mcd_pkg.sv
package mcd_pkg;

    // transition counter width and the count at which the flag rises
    localparam int CNT_W      = 2;
    localparam int MOMENT_THR = 2;

    typedef logic [CNT_W-1:0] tcnt_t;

    // one read response: level bit and momentary bit, returned together
    typedef struct packed {
        logic level;
        logic moment;
    } pair_t;

    function automatic tcnt_t sat_inc(input tcnt_t c);
        return (c == {CNT_W{1'b1}}) ? c : tcnt_t'(c + 1'b1);
    endfunction

    function automatic logic over_thr(input tcnt_t c);
        return (c >= tcnt_t'(MOMENT_THR));
    endfunction

endpackage

// File: rtl/mcd_sync.sv
module mcd_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage[s] <= '0;
                    else     stage[s] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage[s] <= '0;
                    else     stage[s] <= stage[s-1];
                end
            end
        end
    endgenerate

    assign q = stage[STAGES-1];
endmodule

// File: rtl/mcd_elem_track.sv
module mcd_elem_track
    import mcd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic arm,
    input  logic lvl,
    input  logic clr,
    output logic moment
);
    logic  lvl_q;
    tcnt_t cnt;
    logic  edge_seen;

    assign edge_seen = arm && (lvl != lvl_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q <= 1'b0;
            cnt   <= '0;
        end else begin
            lvl_q <= lvl;
            if (clr)
                // an edge coinciding with the read opens the next interval
                cnt <= edge_seen ? tcnt_t'(1) : tcnt_t'(0);
            else if (edge_seen)
                cnt <= sat_inc(cnt);
        end
    end

    assign moment = over_thr(cnt);
endmodule

// File: rtl/mcd_rd_port.sv
module mcd_rd_port
    import mcd_pkg::*;
#(
    parameter int N_ELEM = 8,
    parameter int IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic [IDX_W-1:0]  idx,
    input  logic [N_ELEM-1:0] lvl,
    input  logic [N_ELEM-1:0] moment,
    output logic [N_ELEM-1:0] clr,
    output logic              valid,
    output pair_t             resp
);
    pair_t pick;

    always_comb begin
        pick = '0;
        if (int'(idx) < N_ELEM) begin
            pick.level  = lvl[idx];
            pick.moment = moment[idx];
        end
    end

    generate
        for (genvar i = 0; i < N_ELEM; i++) begin : g_clr
            assign clr[i] = req && (idx == IDX_W'(i));
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            resp  <= '0;
        end else begin
            valid <= req;
            if (req) resp <= pick;
        end
    end
endmodule

// File: rtl/mcd_bank.sv
module mcd_bank
    import mcd_pkg::*;
#(
    parameter int N_ELEM      = 8,
    parameter int SYNC_STAGES = 2,
    localparam int IDX_W      = (N_ELEM > 1) ? $clog2(N_ELEM) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_ELEM-1:0] elem_in,
    input  logic              rd_req,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_valid,
    output logic              rd_state,
    output logic              rd_moment,
    output logic [N_ELEM-1:0] rt_state
);
    localparam int WARM_MAX = SYNC_STAGES + 1;
    localparam int WARM_W   = $clog2(WARM_MAX + 1);

    logic [N_ELEM-1:0] lvl;
    logic [N_ELEM-1:0] moment;
    logic [N_ELEM-1:0] clr;
    logic [WARM_W-1:0] warm;
    logic              arm;
    pair_t             resp;

    mcd_sync #(.WIDTH(N_ELEM), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (elem_in),
        .q   (lvl)
    );

    // hold off edge counting until the synchronizer holds real input levels
    always_ff @(posedge clk) begin
        if (rst)                         warm <= '0;
        else if (warm != WARM_W'(WARM_MAX)) warm <= warm + 1'b1;
    end
    assign arm = (warm == WARM_W'(WARM_MAX));

    generate
        for (genvar i = 0; i < N_ELEM; i++) begin : g_elem
            mcd_elem_track u_trk (
                .clk    (clk),
                .rst    (rst),
                .arm    (arm),
                .lvl    (lvl[i]),
                .clr    (clr[i]),
                .moment (moment[i])
            );
        end
    endgenerate

    mcd_rd_port #(.N_ELEM(N_ELEM), .IDX_W(IDX_W)) u_rd (
        .clk    (clk),
        .rst    (rst),
        .req    (rd_req),
        .idx    (rd_idx),
        .lvl    (lvl),
        .moment (moment),
        .clr    (clr),
        .valid  (rd_valid),
        .resp   (resp)
    );

    assign rd_state  = resp.level;
    assign rd_moment = resp.moment;
    assign rt_state  = lvl;
endmodule

// File: rtl/mcd_bank_chk.sv
module mcd_bank_chk #(
    parameter int N_ELEM = 8,
    parameter int IDX_W  = 3
) (
    input logic              clk,
    input logic              rst,
    input logic [N_ELEM-1:0] elem_in,
    input logic              rd_req,
    input logic [IDX_W-1:0]  rd_idx,
    input logic              rd_valid,
    input logic              rd_state,
    input logic              rd_moment,
    input logic [N_ELEM-1:0] rt_state
);
    // cycles since reset, saturating, gates looks into the past
    logic [1:0] age;
    always_ff @(posedge clk) begin
        if (rst)              age <= '0;
        else if (age != 2'd3) age <= age + 1'b1;
    end

    assert_valid_follows_R1: assert property (@(posedge clk) disable iff (rst)
        rd_req |=> rd_valid);

    assert_valid_idle_R1: assert property (@(posedge clk) disable iff (rst)
        !rd_req |=> !rd_valid);

    assert_rt_delay_R2: assert property (@(posedge clk) disable iff (rst)
        (age >= 2'd2) |-> (rt_state == $past(elem_in, 2)));

    assert_state_match_R2: assert property (@(posedge clk) disable iff (rst)
        (rd_req && int'(rd_idx) < N_ELEM) |=> (rd_state == $past(rt_state[rd_idx])));

    assert_back_to_back_clear_R5: assert property (@(posedge clk) disable iff (rst)
        (rd_req && (age != 2'd0) && $past(rd_req) && (rd_idx == $past(rd_idx))) |=> !rd_moment);

    assert_reset_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        (age == 2'd0) |-> (!rd_valid && !rd_moment));
endmodule

bind mcd_bank mcd_bank_chk #(.N_ELEM(N_ELEM), .IDX_W(IDX_W)) u_mcd_chk (
    .clk       (clk),
    .rst       (rst),
    .elem_in   (elem_in),
    .rd_req    (rd_req),
    .rd_idx    (rd_idx),
    .rd_valid  (rd_valid),
    .rd_state  (rd_state),
    .rd_moment (rd_moment),
    .rt_state  (rt_state)
);

// File: tb/test_mcd_bank.sv
`timescale 1ns/1ps
module test_mcd_bank;
    localparam int N  = 8;
    localparam int IW = 3;
    localparam int NV = 12;

    // vector: {element index[6:4], toggle count[3:1], expected momentary bit[0]}
    localparam logic [6:0] VEC [NV] = '{
        {3'd0, 3'd0, 1'b0},   // R3 no transition
        {3'd0, 3'd1, 1'b0},   // R3 single transition
        {3'd0, 3'd2, 1'b1},   // R4 two transitions
        {3'd0, 3'd0, 1'b0},   // R5 cleared by previous read
        {3'd1, 3'd3, 1'b1},   // R4
        {3'd1, 3'd5, 1'b1},   // R7 saturation
        {3'd1, 3'd0, 1'b0},   // R7 single read clears fully
        {3'd7, 3'd2, 1'b1},   // R4 last element
        {3'd7, 3'd1, 1'b0},   // R3
        {3'd4, 3'd4, 1'b1},   // R7
        {3'd4, 3'd1, 1'b0},   // R5
        {3'd3, 3'd2, 1'b1}    // R4
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [N-1:0]  elem_in = 8'hA5;
    logic          rd_req = 1'b0;
    logic [IW-1:0] rd_idx = '0;
    logic          rd_valid, rd_state, rd_moment;
    logic [N-1:0]  rt_state;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    mcd_bank #(.N_ELEM(N)) i_mcd_bank (
        .clk       (clk),
        .rst       (rst),
        .elem_in   (elem_in),
        .rd_req    (rd_req),
        .rd_idx    (rd_idx),
        .rd_valid  (rd_valid),
        .rd_state  (rd_state),
        .rd_moment (rd_moment),
        .rt_state  (rt_state)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic toggle(input int k);
        @(negedge clk);
        elem_in[k] = ~elem_in[k];
        repeat (4) @(negedge clk);
    endtask

    // one read; sampled at the falling edge after the registering edge
    task automatic do_read(input int k, output logic v, output logic s, output logic m);
        @(negedge clk);
        rd_req = 1'b1;
        rd_idx = IW'(k);
        @(negedge clk);
        rd_req = 1'b0;
        v = rd_valid; s = rd_state; m = rd_moment;
    endtask

    // toggle element k so that its synchronized edge meets a read of k
    task automatic toggle_with_read(input int k, output logic s, output logic m);
        @(negedge clk);
        elem_in[k] = ~elem_in[k];
        @(negedge clk);
        @(negedge clk);
        rd_req = 1'b1;
        rd_idx = IW'(k);
        @(negedge clk);
        rd_req = 1'b0;
        s = rd_state; m = rd_moment;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        logic v, s, m;
        repeat (3) @(negedge clk);
        // R9 reset state while reset is still applied
        check("R9 valid in reset", rd_valid, 1'b0);
        check("R9 moment in reset", rd_moment, 1'b0);
        rst = 1'b0;
        repeat (6) @(negedge clk);
        check("R2 rt_state after reset", rt_state, elem_in);
        // R9: levels held through reset are not transitions
        for (int k = 0; k < N; k++) begin
            do_read(k, v, s, m);
            check("R9 no spurious moment", m, 1'b0);
            check("R2 state after reset", s, elem_in[k]);
        end
        @(negedge clk);
        check("R1 valid idle", rd_valid, 1'b0);

        // vector table
        for (int i = 0; i < NV; i++) begin
            for (int t = 0; t < int'(VEC[i][3:1]); t++) toggle(int'(VEC[i][6:4]));
            do_read(int'(VEC[i][6:4]), v, s, m);
            check("R1 valid", v, 1'b1);
            check("R2 state", s, elem_in[VEC[i][6:4]]);
            check(VEC[i][0] ? "R4/R7 moment" : "R3/R5 moment", m, VEC[i][0]);
        end
        check("R2 rt_state", rt_state, elem_in);

        // R8: reading one element leaves the others counting
        toggle(2); toggle(2);
        toggle(5); toggle(5);
        do_read(3, v, s, m);
        check("R8 other element", m, 1'b0);
        do_read(2, v, s, m);
        check("R8 element kept count", m, 1'b1);
        do_read(5, v, s, m);
        check("R8 element kept count", m, 1'b1);

        // R6: edge coinciding with a read belongs to the next interval
        toggle(6); toggle(6);
        toggle_with_read(6, s, m);
        check("R6 read sees prior count", m, 1'b1);
        check("R6 state", s, elem_in[6]);
        do_read(6, v, s, m);
        check("R6 carried edge alone", m, 1'b0);

        toggle(6);
        toggle_with_read(6, s, m);
        check("R6 single before read", m, 1'b0);
        toggle(6);
        do_read(6, v, s, m);
        check("R6 carried edge plus one", m, 1'b1);

        // R5: back-to-back reads of the same element
        toggle(0); toggle(0);
        @(negedge clk);
        rd_req = 1'b1; rd_idx = 3'd0;
        @(negedge clk);
        check("R5 first of pair", rd_moment, 1'b1);
        @(negedge clk);
        rd_req = 1'b0;
        check("R5 second of pair", rd_moment, 1'b0);
        check("R1 valid held", rd_valid, 1'b1);
        @(negedge clk);
        check("R1 valid drops", rd_valid, 1'b0);

        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule